// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. Software programs a horizontal timing word, a vertical timing word, a frame base address and a control word over a simple 32-bit register bus. The block then runs a pixel counter and a line counter. From these it drives active-high horizontal and vertical sync, a data-enable strobe, a one-clock frame-start pulse, and an x/y position inside the active area for a downstream pixel fetch unit. It also exports the frame base address and the pixel-format controls.

Every porch and sync-width field holds its length minus one. The active line width is programmed in groups of 16 pixels. Register writes reach the timing only through shadow copies, and those copies are reloaded only at a frame boundary, so a frame always uses one consistent set of values.

Top module: `lcd_raster_gen`

## Requirements
- R1: Words written at byte offsets 0x000 (horizontal timing), 0x004 (vertical timing), 0x010 (frame base), 0x014 (second base, stored only) and 0x018 (control) read back unchanged on `reg_rdata` at the same offset. A write to any other offset changes nothing, and such an offset reads as zero.
- R2: Each line runs sync, back porch, active, front porch, in that order. Sync lasts horizontal-timing bits 15:8 plus one clocks, back porch bits 31:24 plus one, and front porch bits 23:16 plus one. `hsync` is high only during sync, and `h_count` counts 0,1,2,... from the first sync clock.
- R3: The active part of a line lasts 16 × (horizontal-timing bits 7:2 + 1) clocks.
- R4: Lines follow the same phase order. Vertical sync lasts vertical-timing bits 15:10 plus one lines, back porch bits 31:24 plus one, active bits 9:0 plus one, and front porch bits 23:16 plus one. `vsync` is high during the vertical sync lines. `de` is high only when both axes are in their active phase.
- R5: With horizontal sync 72, back porch 128, 800 active and front porch 24, a line is 1024 clocks. With vertical sync 2, back porch 22, 600 active and front porch 1, a frame is 625 lines.
- R6: A write to a timing word, the frame base or the format bits while the generator runs does not change the frame in progress. It takes effect from the next frame-start. A write that lands on the last clock of a frame takes effect one frame later.
- R7: Timing runs only while control bit 0 (enable) and bit 11 (power) are both 1. Otherwise all outputs are low and `h_count`/`v_count` read 0. Starting and stopping take effect on the second clock edge after the control write. A restart begins at the first clock of vertical sync.
- R8: `frame_start` is high for exactly one clock per frame, on the first clock of vertical sync, with `hsync` and `vsync` high. At that clock `frame_base` carries the frame base word.
- R9: While `de` is high, `pix_x`/`pix_y` give the position inside the active area, starting at 0,0. `pix_depth` carries control bits 3:1 and `bgr_order` carries control bit 8, both taken from the frame's shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| frame_start | output | 1 | One-clock pulse at frame start |
| frame_base | output | 32 | Frame base address of the current frame |
| h_count | output | CNT_W (12) | Clock index within the line |
| v_count | output | CNT_W (12) | Line index within the frame |
| pix_x | output | 10 | Active-area column |
| pix_y | output | 10 | Active-area row |
| pix_depth | output | 3 | Pixel depth code |
| bgr_order | output | 1 | Component order select |

## Verification
A register write and the shadow reload at the end of a frame can fall on the same clock edge. The bench provokes this by timing a horizontal-timing write to land exactly on the last clock of a frame. It judges the result by measuring the lengths of the next two frames: the first must keep the old length and the second must take the new one. A write landing mid-frame, together with a frame-base and format change, is also checked by watching `frame_base` and `pix_depth` hold until the following `frame_start`.

// File: rtl/lcd_raster_pkg.sv
// Shared definitions for the LCD raster timing generator.
// Assumes byte-addressed 32-bit registers on word-aligned offsets.
package lcd_raster_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    localparam int OFS_HTIME = 'h000;
    localparam int OFS_VTIME = 'h004;
    localparam int OFS_BASE0 = 'h010;
    localparam int OFS_BASE1 = 'h014;
    localparam int OFS_CTRL  = 'h018;

    localparam int PPL_W = 6;
    localparam int LPP_W = 10;

endpackage

// File: rtl/lcd_raster_regs.sv
// Register bank: stores the five software-visible words and returns a
// combinational read for the offset on reg_addr.
// Assumes writes at unknown offsets are dropped.
module lcd_raster_regs
    import lcd_raster_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:2]       htime,
    output logic [31:0]       vtime,
    output logic [31:0]       base0,
    output logic              run_req,
    output logic [2:0]        depth,
    output logic              bgr
);

    logic [31:0] htime_q, vtime_q, base0_q, base1_q, ctrl_q;

    // Capture a software write into the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htime_q <= '0;
            vtime_q <= '0;
            base0_q <= '0;
            base1_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_HTIME)) htime_q <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_VTIME)) vtime_q <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_BASE0)) base0_q <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_BASE1)) base1_q <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_CTRL))  ctrl_q  <= reg_wdata;
        end
    end

    // Select the read word for the current offset.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_HTIME)) reg_rdata = htime_q;
        if (reg_addr == ADDR_W'(OFS_VTIME)) reg_rdata = vtime_q;
        if (reg_addr == ADDR_W'(OFS_BASE0)) reg_rdata = base0_q;
        if (reg_addr == ADDR_W'(OFS_BASE1)) reg_rdata = base1_q;
        if (reg_addr == ADDR_W'(OFS_CTRL))  reg_rdata = ctrl_q;
    end

    assign htime   = htime_q[31:2];
    assign vtime   = vtime_q;
    assign base0   = base0_q;
    assign run_req = ctrl_q[0] & ctrl_q[11];
    assign depth   = ctrl_q[3:1];
    assign bgr     = ctrl_q[8];

endmodule

// File: rtl/lcd_raster_axis.sv
// One timing axis: walks sync, back porch, active, front porch, each for
// lens[phase]+1 steps, and keeps a running position from sync start.
// Assumes lens only change while clr is high or on the step that wraps.
module lcd_raster_axis
    import lcd_raster_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  step,
    input  logic [3:0][CNT_W-1:0] lens,
    output phase_e                phase,
    output logic [CNT_W-1:0]      cnt,
    output logic [CNT_W-1:0]      pos,
    output logic                  last
);

    logic phase_end;

    assign phase_end = (cnt == lens[phase]);
    assign last      = step && phase_end && (phase == PH_FRONT);

    // Advance the in-phase count, phase and position on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= PH_SYNC;
            cnt   <= '0;
            pos   <= '0;
        end else if (step) begin
            if (phase_end) begin
                cnt   <= '0;
                phase <= phase_e'(phase + 2'd1);
            end else begin
                cnt <= cnt + 1'b1;
            end
            pos <= last ? '0 : pos + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lens[phase]);                                            // R2

    AST_WRAP_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr) |=> (phase == PH_SYNC && pos == '0));            // R4

endmodule

// File: rtl/lcd_raster_gen.sv
// Top of the LCD raster timing generator. Holds per-frame shadow copies of
// the timing, base and format fields, runs the horizontal axis every clock
// and the vertical axis once per line, and forms the panel strobes.
// Assumes the run request is qualified one clock later so the shadows are
// loaded with the final values before the first frame starts.
module lcd_raster_gen
    import lcd_raster_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              frame_start,
    output logic [31:0]       frame_base,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count,
    output logic [PPL_W+3:0]  pix_x,
    output logic [LPP_W-1:0]  pix_y,
    output logic [2:0]        pix_depth,
    output logic              bgr_order
);

    localparam int X_W = PPL_W + 4;
    localparam int Y_W = LPP_W;

    logic [31:2] htime;
    logic [31:0] vtime, base0;
    logic        run_req, bgr;
    logic [2:0]  depth;

    lcd_raster_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .htime     (htime),
        .vtime     (vtime),
        .base0     (base0),
        .run_req   (run_req),
        .depth     (depth),
        .bgr       (bgr)
    );

    logic        active;
    logic [31:2] sh_htime;
    logic [31:0] sh_vtime, sh_base;
    logic [2:0]  sh_depth;
    logic        sh_bgr;
    logic        h_last, v_last, shadow_load;

    // Qualify the run request one clock late so shadows settle first.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= run_req;
    end

    assign shadow_load = !active || v_last;

    // Reload the per-frame shadow copies while idle or at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_htime <= '0;
            sh_vtime <= '0;
            sh_base  <= '0;
            sh_depth <= '0;
            sh_bgr   <= 1'b0;
        end else if (shadow_load) begin
            sh_htime <= htime;
            sh_vtime <= vtime;
            sh_base  <= base0;
            sh_depth <= depth;
            sh_bgr   <= bgr;
        end
    end

    logic [3:0][CNT_W-1:0] h_lens, v_lens;

    assign h_lens[PH_SYNC]   = CNT_W'(sh_htime[15:8]);
    assign h_lens[PH_BACK]   = CNT_W'(sh_htime[31:24]);
    assign h_lens[PH_ACTIVE] = CNT_W'({sh_htime[7:2], 4'hF});
    assign h_lens[PH_FRONT]  = CNT_W'(sh_htime[23:16]);
    assign v_lens[PH_SYNC]   = CNT_W'(sh_vtime[15:10]);
    assign v_lens[PH_BACK]   = CNT_W'(sh_vtime[31:24]);
    assign v_lens[PH_ACTIVE] = CNT_W'(sh_vtime[9:0]);
    assign v_lens[PH_FRONT]  = CNT_W'(sh_vtime[23:16]);

    phase_e           h_phase, v_phase;
    logic [CNT_W-1:0] h_cnt, v_cnt, h_pos, v_pos;

    lcd_raster_axis #(.CNT_W(CNT_W)) u_haxis (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!active),
        .step  (1'b1),
        .lens  (h_lens),
        .phase (h_phase),
        .cnt   (h_cnt),
        .pos   (h_pos),
        .last  (h_last)
    );

    lcd_raster_axis #(.CNT_W(CNT_W)) u_vaxis (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!active),
        .step  (h_last),
        .lens  (v_lens),
        .phase (v_phase),
        .cnt   (v_cnt),
        .pos   (v_pos),
        .last  (v_last)
    );

    assign hsync       = active && (h_phase == PH_SYNC);
    assign vsync       = active && (v_phase == PH_SYNC);
    assign de          = active && (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
    assign frame_start = active && (h_pos == '0) && (v_pos == '0);
    assign frame_base  = sh_base;
    assign h_count     = active ? h_pos : '0;
    assign v_count     = active ? v_pos : '0;
    assign pix_x       = de ? X_W'(h_cnt) : '0;
    assign pix_y       = de ? Y_W'(v_cnt) : '0;
    assign pix_depth   = sh_depth;
    assign bgr_order   = sh_bgr;

    AST_FS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);                                  // R8

    AST_FS_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (hsync && vsync));                              // R8

    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));                                     // R4

    AST_START_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> frame_start);                                 // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !v_last) |=> ($stable(sh_htime) && $stable(sh_vtime)
                                 && $stable(sh_base) && $stable(sh_depth))); // R6

endmodule

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, frame_base;
    logic        hsync, vsync, de, frame_start, bgr_order;
    logic [11:0] h_count, v_count;
    logic [9:0]  pix_x, pix_y;
    logic [2:0]  pix_depth;

    always #5 clk = ~clk;

    lcd_raster_gen u_lcd_raster_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync),
        .vsync(vsync), .de(de), .frame_start(frame_start),
        .frame_base(frame_base), .h_count(h_count), .v_count(v_count),
        .pix_x(pix_x), .pix_y(pix_y), .pix_depth(pix_depth),
        .bgr_order(bgr_order)
    );

    int n_chk = 0;
    int n_fail = 0;
    int s_tot, s_de, s_vs, s_hs, s_rises, s_rise2, s_first, s_fx, s_fy, s_mx, s_my, s_fs;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_h(int sw, int bp, int act, int fp);
        return ((bp - 1) << 24) | ((fp - 1) << 16) | ((sw - 1) << 8) | ((act / 16 - 1) << 2);
    endfunction

    function automatic logic [31:0] enc_v(int sw, int bp, int act, int fp);
        return ((bp - 1) << 24) | ((fp - 1) << 16) | ((sw - 1) << 10) | (act - 1);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, int'(reg_rdata), int'(exp));
    endtask

    task automatic wait_fs();
        for (int k = 0; k < 40000 && !frame_start; k++) @(negedge clk);
    endtask

    // Measure one frame starting on a sampled frame_start clock.
    task automatic scan_frame();
        bit prev;
        prev = 1'b0;
        s_tot = 0; s_de = 0; s_vs = 0; s_hs = 0; s_rises = 0; s_rise2 = -1;
        s_first = -1; s_fx = -1; s_fy = -1; s_mx = 0; s_my = 0; s_fs = 0;
        do begin
            if (frame_start) s_fs++;
            if (de) begin
                s_de++;
                if (s_first < 0) begin s_first = s_tot; s_fx = int'(pix_x); s_fy = int'(pix_y); end
                if (int'(pix_x) > s_mx) s_mx = int'(pix_x);
                if (int'(pix_y) > s_my) s_my = int'(pix_y);
            end
            if (vsync) s_vs++;
            if (hsync) s_hs++;
            if (hsync && !prev) begin
                s_rises++;
                if (s_rises == 2) s_rise2 = s_tot;
            end
            prev = hsync;
            s_tot++;
            @(negedge clk);
        end while (!frame_start && s_tot < 40000);
    endtask

    // Program timing and base while stopped, then start.
    task automatic start(input logic [31:0] h, input logic [31:0] v, input logic [31:0] b,
                         input logic [31:0] c);
        wr(8'h18, 32'h0);
        @(negedge clk);
        wr(8'h00, h);
        wr(8'h04, v);
        wr(8'h10, b);
        wr(8'h18, c);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!hsync && !vsync && !de && !frame_start, "R7 reset outputs", int'({hsync, vsync, de, frame_start}), 0);
        chk(h_count == 0 && v_count == 0, "R7 reset counters", int'(h_count), 0);
        rd_chk(8'h18, 32'h0, "R1 reset ctrl");
    endtask

    task automatic t_regs();
        wr(8'h00, 32'h1122_3344);
        wr(8'h04, 32'h5566_7788);
        wr(8'h10, 32'h8000_1000);
        wr(8'h14, 32'hCAFE_0004);
        wr(8'h18, 32'h0000_01A5);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h1122_3344, "R1 htime");
        rd_chk(8'h04, 32'h5566_7788, "R1 vtime");
        rd_chk(8'h10, 32'h8000_1000, "R1 base");
        rd_chk(8'h14, 32'hCAFE_0004, "R1 second base");
        rd_chk(8'h18, 32'h0000_01A5, "R1 ctrl");
        rd_chk(8'h20, 32'h0, "R1 unmapped");
        rd_chk(8'h0C, 32'h0, "R1 unmapped 0C");
    endtask

    task automatic t_gating();
        int busy;
        wr(8'h00, enc_h(2, 3, 16, 4));
        wr(8'h04, enc_v(2, 2, 4, 2));
        wr(8'h18, 32'h0000_0001);
        busy = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (hsync || vsync || de || frame_start || h_count != 0) busy++;
        end
        chk(busy == 0, "R7 enable without power", busy, 0);
        wr(8'h18, 32'h0000_0800);
        busy = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (hsync || vsync || de || frame_start || h_count != 0) busy++;
        end
        chk(busy == 0, "R7 power without enable", busy, 0);
    endtask

    task automatic t_small();
        int bad;
        wr(8'h18, 32'h0);
        @(negedge clk);
        wr(8'h00, enc_h(2, 3, 16, 4));
        wr(8'h04, enc_v(2, 2, 4, 2));
        wr(8'h10, 32'h0004_0000);
        wr(8'h18, 32'h0000_0801);
        chk(!frame_start, "R7 start latency first edge", int'(frame_start), 0);
        @(negedge clk);
        chk(frame_start && hsync && vsync, "R8 start at vsync", int'({frame_start, hsync, vsync}), 7);
        chk(frame_base == 32'h0004_0000, "R8 frame base", int'(frame_base), 32'h0004_0000);
        bad = 0;
        for (int i = 0; i < 25; i++) begin
            if (h_count != 12'(i) || hsync != (i < 2)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 line phase order", bad, 0);
        wait_fs();
        scan_frame();
        chk(s_tot == 250, "R2 R4 frame clocks", s_tot, 250);
        chk(s_rise2 == 25, "R2 line length", s_rise2, 25);
        chk(s_hs == 20, "R2 hsync clocks", s_hs, 20);
        chk(s_vs == 50, "R4 vsync clocks", s_vs, 50);
        chk(s_de == 64, "R4 de clocks", s_de, 64);
        chk(s_first == 105, "R4 first de clock", s_first, 105);
        chk(s_fx == 0 && s_fy == 0, "R9 first position", s_fx + s_fy, 0);
        chk(s_mx == 15 && s_my == 3, "R9 last position", s_mx * 100 + s_my, 1503);
        chk(s_fs == 1, "R8 one pulse per frame", s_fs, 1);
    endtask

    task automatic t_wide();
        start(enc_h(2, 3, 48, 4), enc_v(2, 2, 4, 2), 32'h0, 32'h0000_0801);
        scan_frame();
        chk(s_rise2 == 57, "R3 line length", s_rise2, 57);
        chk(s_de == 192, "R3 de clocks", s_de, 192);
        chk(s_mx == 47, "R3 last column", s_mx, 47);
    endtask

    task automatic t_800();
        start(enc_h(72, 128, 800, 24), enc_v(2, 2, 4, 2), 32'h0, 32'h0000_0801);
        scan_frame();
        chk(s_rise2 == 1024, "R5 line of 1024", s_rise2, 1024);
        chk(s_tot == 10240, "R5 frame clocks horizontal", s_tot, 10240);
        chk(s_de == 3200, "R5 de clocks horizontal", s_de, 3200);
        start(enc_h(1, 1, 16, 1), enc_v(2, 22, 600, 1), 32'h0, 32'h0000_0801);
        scan_frame();
        chk(s_rises == 625, "R5 frame of 625 lines", s_rises, 625);
        chk(s_tot == 11875, "R5 frame clocks vertical", s_tot, 11875);
        chk(s_vs == 38, "R5 vsync clocks", s_vs, 38);
        chk(s_first == 458, "R5 first de clock", s_first, 458);
        chk(s_my == 599, "R5 last row", s_my, 599);
    endtask

    task automatic t_shadow();
        int k;
        start(enc_h(2, 3, 16, 4), enc_v(2, 2, 4, 2), 32'h0000_1000, 32'h0000_090B);
        chk(pix_depth == 3'd5 && bgr_order, "R9 format export", int'({bgr_order, pix_depth}), 13);
        wait_fs();
        k = 0;
        do begin
            if (k == 30) begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = enc_h(2, 3, 16, 10); end
            if (k == 31) begin reg_addr = 8'h10; reg_wdata = 32'h0000_2000; end
            if (k == 32) begin reg_addr = 8'h18; reg_wdata = 32'h0000_0803; end
            if (k == 33) reg_wr = 1'b0;
            if (k == 40) begin
                chk(frame_base == 32'h0000_1000, "R6 base held mid-frame", int'(frame_base), 32'h1000);
                chk(pix_depth == 3'd5, "R6 format held mid-frame", int'(pix_depth), 5);
            end
            k++;
            @(negedge clk);
        end while (!frame_start && k < 40000);
        chk(k == 250, "R6 current frame unchanged", k, 250);
        chk(frame_base == 32'h0000_2000, "R6 base at next frame", int'(frame_base), 32'h2000);
        chk(pix_depth == 3'd1 && !bgr_order, "R6 format at next frame", int'({bgr_order, pix_depth}), 1);
        scan_frame();
        chk(s_tot == 310, "R6 new timing next frame", s_tot, 310);
        k = 0;
        do begin
            if (k == 309) begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = enc_h(2, 3, 16, 4); end
            k++;
            @(negedge clk);
        end while (!frame_start && k < 40000);
        reg_wr = 1'b0;
        scan_frame();
        chk(s_tot == 310, "R6 write on last clock waits a frame", s_tot, 310);
        scan_frame();
        chk(s_tot == 250, "R6 write on last clock then applies", s_tot, 250);
    endtask

    task automatic t_restart();
        int busy;
        repeat (37) @(negedge clk);
        wr(8'h18, 32'h0);
        @(negedge clk);
        busy = 0;
        for (int k = 0; k < 20; k++) begin
            if (hsync || vsync || de || frame_start || h_count != 0 || v_count != 0) busy++;
            @(negedge clk);
        end
        chk(busy == 0, "R7 stop clears outputs", busy, 0);
        wr(8'h18, 32'h0000_0801);
        @(negedge clk);
        chk(frame_start && vsync && h_count == 0 && v_count == 0, "R7 restart at vsync",
            int'({frame_start, vsync}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gating();
        t_small();
        t_wide();
        t_800();
        t_shadow();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule